// File: doc/BRIEF.md
# External Memory Access Cycle Sequencer

This block runs one read or one write access to an asynchronous static memory on a single chip select. It drives three registered, active-low outputs: chip select, read strobe and write strobe. A request arrives over a valid/ready handshake and carries everything the access needs: the direction, a setup count, a pulse count, a hold count, a total cycle count, a two-bit wait mode, and one bit per direction that picks which strobe times completion.

Inside an access, cycles are numbered from 0. Chip select stays low for the whole access. The read strobe (for a read) or the write strobe (for a write) is low from cycle `setup` up to and including cycle `setup+pulse-1`.

An active-low wait input from the memory can stretch an access, depending on the wait mode:
- Wait is ignored.
- Wait freezes the access anywhere inside the strobe pulse, and the access resumes where it stopped.
- Wait stretches only the final pulse cycle, so the memory signals readiness at the end of the pulse.

When the completion point is reached, read data is captured and a one-cycle done pulse is raised.

Top module: `extmem_access_seq`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, done and cfg_err are low, read data is zero and req_ready is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low in every cycle in which chip select is low. A request offered during an access is ignored, and its fields do not alter the running access.
- R3: Chip select goes low in the cycle after acceptance. It stays low for L cycles plus the number of stalled cycles. L is the largest of setup+pulse+hold, total and 1.
- R4: The direction strobe (the read strobe when req_write is 0, the write strobe when it is 1) is low exactly in access cycles setup through setup+pulse-1. The other strobe stays high. With pulse 0 neither strobe falls. The two strobes are never low together.
- R5: The completion bit for the access direction is req_rd_by_strobe for reads and req_wr_by_strobe for writes.
  - If that bit is 1 and pulse is nonzero, completion is at the clock edge where the direction strobe rises.
  - Otherwise, completion is at the edge where chip select rises.
  - done is high for exactly the one cycle after the completion edge.
- R6: At the completion edge of a read, rdata takes the mem_rdata value present in the cycle before that edge. A write leaves rdata unchanged.
- R7: With wait mode 0 or 1, mem_wait_n has no effect on any output.
- R8: With wait mode 2, any access cycle in which the direction strobe is low and mem_wait_n is low is repeated. All strobes stay unchanged and done stays low. The access then continues from the same point.
- R9: With wait mode 2 or 3, mem_wait_n low during setup or hold cycles has no effect.
- R10: With wait mode 3, only the last pulse cycle (setup+pulse-1) is repeated while mem_wait_n is low. Earlier pulse cycles are not stretched.
- R11: cfg_err is high in every cycle of an access whose wait mode is 2 or 3 and whose hold is 0. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_setup | input | 6 | Strobe setup cycles |
| req_pulse | input | 6 | Strobe pulse cycles |
| req_hold | input | 6 | Strobe hold cycles |
| req_total | input | 7 | Minimum total access cycles |
| req_wait_mode | input | 2 | 0/1 ignore, 2 freeze, 3 ready |
| req_rd_by_strobe | input | 1 | Read completion timed by read strobe (1) or chip select (0) |
| req_wr_by_strobe | input | 1 | Write completion timed by write strobe (1) or chip select (0) |
| mem_wait_n | input | 1 | Active-low wait from memory, synchronous to clk |
| mem_rdata | input | DW | Data bus from memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Captured read data |
| cfg_err | output | 1 | Wait enabled with zero hold |

## Verification
The hardest situation to reach is a freeze that lands on the last pulse cycle of a strobe-timed read. Here the completion edge, the data capture and the strobe rise all have to slip by exactly the stalled cycles. The bench drives the memory data with a value that changes every cycle, and it lowers mem_wait_n over a window counted from acceptance that covers that final pulse cycle. The captured word then shows which edge was used. Wait windows placed wholly inside setup or hold show that those phases ignore the input.

// File: rtl/ems_pkg.sv
package ems_pkg;
  localparam int TW = 6;          // setup/pulse/hold count width
  localparam int LW = 7;          // total cycle count width
  localparam int CW = TW + 2;     // holds 3*(2^TW-1)

  typedef enum logic [1:0] {
    WM_OFF    = 2'd0,
    WM_RSVD   = 2'd1,
    WM_FREEZE = 2'd2,
    WM_READY  = 2'd3
  } ems_wmode_e;

  typedef struct packed {
    logic             write;
    logic [TW-1:0]    setup;
    logic [TW-1:0]    pulse;
    logic [TW-1:0]    hold;
    logic [LW-1:0]    total;
    ems_wmode_e       wmode;
    logic             rd_by_strobe;
    logic             wr_by_strobe;
  } ems_cfg_t;
endpackage

// File: rtl/ems_rst_sync.sv
module ems_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta   <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta   <= 1'b1;
      srst_n <= meta;
    end
  end
endmodule

// File: rtl/ems_phase_ctr.sv
module ems_phase_ctr
  import ems_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  ems_cfg_t      cfg,
  input  logic          wait_n,
  output logic          active,
  output logic          active_nx,
  output logic [CW-1:0] cnt_nx,
  output logic          capture
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] s_w, pend, body, len, len_m1;
  logic          in_pulse, last_pulse, stall, adv, at_end, by_strobe, cnt_en;

  // access length and phase decode
  always_comb begin
    s_w    = CW'(cfg.setup);
    pend   = s_w + CW'(cfg.pulse);
    body   = pend + CW'(cfg.hold);
    len    = (body > CW'(cfg.total)) ? body : CW'(cfg.total);
    if (len == '0) len = CW'(1);
    len_m1 = len - CW'(1);

    in_pulse   = active && (cnt >= s_w) && (cnt < pend);
    last_pulse = in_pulse && (cnt == pend - CW'(1));

    unique case (cfg.wmode)
      WM_FREEZE: stall = in_pulse && !wait_n;
      WM_READY:  stall = last_pulse && !wait_n;
      default:   stall = 1'b0;
    endcase

    adv       = active && !stall;
    at_end    = (cnt == len_m1);
    by_strobe = (cfg.write ? cfg.wr_by_strobe : cfg.rd_by_strobe) && (cfg.pulse != '0);
    capture   = adv && (by_strobe ? last_pulse : at_end);
  end

  // next state
  always_comb begin
    cnt_nx    = cnt;
    active_nx = active;
    if (start) begin
      cnt_nx    = '0;
      active_nx = 1'b1;
    end else if (adv) begin
      if (at_end) active_nx = 1'b0;
      else        cnt_nx    = cnt + CW'(1);
    end
    cnt_en = start || adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (cnt_en) begin
      cnt    <= cnt_nx;
      active <= active_nx;
    end
  end
endmodule

// File: rtl/ems_strobe_gen.sv
module ems_strobe_gen
  import ems_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_nx,
  input  logic [CW-1:0] cnt_nx,
  input  logic [TW-1:0] nx_setup,
  input  logic [TW-1:0] nx_pulse,
  input  logic          nx_write,
  input  logic          nx_err,
  input  logic          capture,
  input  logic          cap_write,
  input  logic [DW-1:0] mem_rdata,
  output logic          cs_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cfg_err
);
  logic [CW-1:0] s_w, pend;
  logic          strobe_on, cs_n_d, rd_n_d, wr_n_d, err_d, rdata_en;

  always_comb begin
    s_w       = CW'(nx_setup);
    pend      = s_w + CW'(nx_pulse);
    strobe_on = active_nx && (cnt_nx >= s_w) && (cnt_nx < pend);
    cs_n_d    = !active_nx;
    rd_n_d    = !(strobe_on && !nx_write);
    wr_n_d    = !(strobe_on && nx_write);
    err_d     = active_nx && nx_err;
    rdata_en  = capture && !cap_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n    <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      done    <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      cs_n    <= cs_n_d;
      rd_n    <= rd_n_d;
      wr_n    <= wr_n_d;
      done    <= capture;
      cfg_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_en) rdata <= mem_rdata;
  end
endmodule

// File: rtl/extmem_access_seq.sv
module extmem_access_seq
  import ems_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [TW-1:0] req_setup,
  input  logic [TW-1:0] req_pulse,
  input  logic [TW-1:0] req_hold,
  input  logic [LW-1:0] req_total,
  input  logic [1:0]    req_wait_mode,
  input  logic          req_rd_by_strobe,
  input  logic          req_wr_by_strobe,
  input  logic          mem_wait_n,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_cs_n,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          cfg_err
);
  logic          rst_q_n;
  logic          active, active_nx, start, capture, err_nx;
  logic [CW-1:0] cnt_nx;
  ems_cfg_t      req_cfg, cfg_q, cfg_nx;

  ems_rst_sync i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  always_comb begin
    req_cfg = '{write:        req_write,
                setup:        req_setup,
                pulse:        req_pulse,
                hold:         req_hold,
                total:        req_total,
                wmode:        ems_wmode_e'(req_wait_mode),
                rd_by_strobe: req_rd_by_strobe,
                wr_by_strobe: req_wr_by_strobe};
    req_ready = !active;
    start     = req_valid && !active;
    cfg_nx    = start ? req_cfg : cfg_q;
    err_nx    = cfg_nx.wmode[1] && (cfg_nx.hold == '0);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)   cfg_q <= '0;
    else if (start) cfg_q <= req_cfg;
  end

  ems_phase_ctr i_phase (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start     (start),
    .cfg       (cfg_q),
    .wait_n    (mem_wait_n),
    .active    (active),
    .active_nx (active_nx),
    .cnt_nx    (cnt_nx),
    .capture   (capture)
  );

  ems_strobe_gen #(.DW(DW)) i_strobe (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .active_nx (active_nx),
    .cnt_nx    (cnt_nx),
    .nx_setup  (cfg_nx.setup),
    .nx_pulse  (cfg_nx.pulse),
    .nx_write  (cfg_nx.write),
    .nx_err    (err_nx),
    .capture   (capture),
    .cap_write (cfg_q.write),
    .mem_rdata (mem_rdata),
    .cs_n      (mem_cs_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n),
    .done      (done),
    .rdata     (rdata),
    .cfg_err   (cfg_err)
  );
endmodule

// File: rtl/ems_seq_chk.sv
module ems_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic rd_n,
  input logic wr_n,
  input logic done,
  input logic cfg_err,
  input logic req_ready,
  input logic wait_n,
  input logic freeze_sel
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !cs_n);

  // R2
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !req_ready);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_sel && !cs_n && (!rd_n || !wr_n) && !wait_n)
      |=> ($stable({cs_n, rd_n, wr_n}) && !done));

  // R11
  err_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !cs_n);
endmodule

bind extmem_access_seq ems_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .cs_n       (mem_cs_n),
  .rd_n       (mem_rd_n),
  .wr_n       (mem_wr_n),
  .done       (done),
  .cfg_err    (cfg_err),
  .req_ready  (req_ready),
  .wait_n     (mem_wait_n),
  .freeze_sel (cfg_q.wmode == ems_pkg::WM_FREEZE)
);

// File: tb/test_extmem_access_seq.sv
`timescale 1ns/1ps
module test_extmem_access_seq;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [5:0]    req_setup, req_pulse, req_hold;
  logic [6:0]    req_total;
  logic [1:0]    req_wait_mode;
  logic          req_rd_by_strobe, req_wr_by_strobe;
  logic          mem_wait_n;
  logic [DW-1:0] mem_rdata;
  logic          mem_cs_n, mem_rd_n, mem_wr_n, done, cfg_err;
  logic [DW-1:0] rdata;
  logic [DW-1:0] tick = '0;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= tick + 16'd1;
  assign mem_rdata = tick ^ 16'h5A00;

  extmem_access_seq #(.DW(DW)) i_extmem_access_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_setup(req_setup), .req_pulse(req_pulse),
    .req_hold(req_hold), .req_total(req_total), .req_wait_mode(req_wait_mode),
    .req_rd_by_strobe(req_rd_by_strobe), .req_wr_by_strobe(req_wr_by_strobe),
    .mem_wait_n(mem_wait_n), .mem_rdata(mem_rdata), .mem_cs_n(mem_cs_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .done(done), .rdata(rdata),
    .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_setup = '0;
    req_pulse = '0; req_hold = '0; req_total = '0; req_wait_mode = '0;
    req_rd_by_strobe = 1'b0; req_wr_by_strobe = 1'b0; mem_wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk({mem_cs_n, mem_rd_n, mem_wr_n} == 3'b111, "R1", "strobes idle", {mem_cs_n, mem_rd_n, mem_wr_n}, 7);
    chk(!done && !cfg_err, "R1", "done/cfg_err idle", {done, cfg_err}, 0);
    chk(req_ready == 1'b1, "R1", "ready idle", req_ready, 1);
    chk(rdata == '0, "R1", "rdata reset", rdata, 0);
  endtask

  // One access; the model walks access cycles k and counts stalls from the rules.
  task automatic do_access(input string tag, input bit wr, input int s, input int p,
                           input int h, input int t, input int wm, input bit rdc,
                           input bit wrc, input int wfrom, input int wlen,
                           input bit keep, input int exp_stall);
    int e, k, nst, cs_low, prof_bad, done_bad, rdy_bad, err_bad;
    bit fin, done_exp, inp, stall, ctl, err_exp;
    logic [DW-1:0] rd_exp;
    e = s + p + h;
    if (t > e) e = t;
    if (e == 0) e = 1;
    err_exp = (wm >= 2) && (h == 0);
    @(negedge clk); #1;
    rd_exp = rdata;
    req_write = wr; req_setup = 6'(s); req_pulse = 6'(p); req_hold = 6'(h);
    req_total = 7'(t); req_wait_mode = 2'(wm); req_rd_by_strobe = rdc;
    req_wr_by_strobe = wrc; req_valid = 1'b1; mem_wait_n = 1'b1;
    @(negedge clk); #1;
    if (keep) begin
      req_write = ~wr; req_setup = 6'd0; req_pulse = 6'd9; req_hold = 6'd0;
      req_total = 7'd0;
    end else begin
      req_valid = 1'b0;
    end
    k = 0; nst = 0; cs_low = 0; prof_bad = 0; done_bad = 0; rdy_bad = 0;
    err_bad = 0; fin = 0; done_exp = 0;
    for (int j = 0; j < 600 && !fin; j++) begin
      inp = (k >= s) && (k < s + p);
      if (mem_cs_n == 1'b0) cs_low++;
      if (mem_cs_n !== 1'b0 || mem_rd_n !== !(inp && !wr) || mem_wr_n !== !(inp && wr))
        prof_bad++;
      if (done !== done_exp) done_bad++;
      if (req_ready !== 1'b0) rdy_bad++;
      if (cfg_err !== err_exp) err_bad++;
      mem_wait_n = !(j >= wfrom && j < wfrom + wlen);
      stall = (wm == 2 && inp && !mem_wait_n) ||
              (wm == 3 && inp && k == s + p - 1 && !mem_wait_n);
      done_exp = 0;
      if (!stall) begin
        ctl = (wr ? wrc : rdc) && (p > 0);
        if (ctl ? (k == s + p - 1) : (k == e - 1)) begin
          done_exp = 1;
          if (!wr) rd_exp = mem_rdata;
        end
        if (k == e - 1) fin = 1;
        else k++;
      end else begin
        nst++;
      end
      @(negedge clk); #1;
    end
    if (mem_cs_n == 1'b0) cs_low++;
    if (done !== done_exp) done_bad++;
    req_valid = 1'b0;
    mem_wait_n = 1'b1;
    chk(prof_bad == 0, "R4", {tag, " strobe profile"}, prof_bad, 0);
    chk(cs_low == e + exp_stall, tag, "chip select low cycles", cs_low, e + exp_stall);
    chk(mem_cs_n && mem_rd_n && mem_wr_n, "R3", {tag, " strobes high after end"}, {mem_cs_n, mem_rd_n, mem_wr_n}, 7);
    chk(done_bad == 0, "R5", {tag, " done timing"}, done_bad, 0);
    chk(rdy_bad == 0 && req_ready, "R2", {tag, " ready handshake"}, rdy_bad, 0);
    chk(err_bad == 0 && !cfg_err, "R11", {tag, " cfg_err"}, err_bad, 0);
    chk(rdata == rd_exp, "R6", {tag, " captured data"}, rdata, rd_exp);
    @(negedge clk); #1;
    chk(mem_cs_n == 1'b1, "R2", {tag, " no second access"}, mem_cs_n, 1);
  endtask

  task automatic test_lengths();
    do_access("R3", 0, 2, 3, 1, 4, 0, 0, 0, 0, 0, 0, 0);
    do_access("R3", 0, 1, 2, 1, 10, 0, 0, 0, 0, 0, 0, 0);
    do_access("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_completion();
    do_access("R5", 1, 1, 2, 2, 0, 0, 0, 1, 0, 0, 0, 0);
    do_access("R6", 0, 2, 3, 2, 9, 0, 1, 0, 0, 0, 0, 0);
    do_access("R6", 1, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    do_access("R5", 0, 2, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic test_freeze();
    do_access("R8", 0, 2, 4, 1, 0, 2, 1, 0, 3, 3, 0, 3);
    do_access("R8", 1, 1, 3, 2, 0, 2, 0, 1, 2, 2, 0, 2);
    do_access("R8", 0, 1, 2, 1, 0, 2, 1, 0, 2, 4, 0, 4);
  endtask

  task automatic test_outside_pulse();
    do_access("R9", 0, 3, 2, 2, 0, 2, 0, 0, 0, 3, 0, 0);
    do_access("R9", 0, 3, 2, 2, 0, 2, 0, 0, 5, 2, 0, 0);
    do_access("R9", 1, 3, 2, 2, 0, 3, 0, 0, 0, 3, 0, 0);
  endtask

  task automatic test_ready();
    do_access("R10", 0, 1, 3, 1, 0, 3, 1, 0, 0, 6, 0, 3);
    do_access("R10", 1, 1, 3, 1, 0, 3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_ignored();
    do_access("R7", 0, 1, 3, 1, 0, 0, 0, 0, 0, 40, 0, 0);
    do_access("R7", 1, 1, 3, 1, 0, 1, 0, 1, 0, 40, 0, 0);
  endtask

  task automatic test_cfg_err();
    do_access("R11", 0, 1, 2, 0, 0, 2, 0, 0, 0, 0, 0, 0);
    do_access("R11", 1, 1, 2, 0, 5, 3, 0, 0, 2, 2, 0, 2);
    do_access("R11", 0, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic test_busy();
    do_access("R2", 0, 2, 2, 2, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_lengths();
    test_completion();
    test_freeze();
    test_outside_pulse();
    test_ready();
    test_ignored();
    test_cfg_err();
    test_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule